// File: doc/BRIEF.md
# Prescaled Free-Running Counter with Capture

This block keeps a 16-bit up-counter running from the bus clock. A programmable divider sits in front of the counter, so the counter advances once every 1, 4, 8 or 16 clock cycles. When the count passes from all ones back to zero, an overflow flag is set. If the overflow interrupt enable bit is also set, the interrupt request goes high. Three capture channels take a one-cycle strobe with a channel number. The selected channel freezes the current count in its own 16-bit register and sets its own flag.

Software uses a byte-wide read/write port. Through it, software reads the counter and the capture registers a byte at a time. It also programs the control register (divider select and interrupt enable) and acknowledges flags by writing ones. The divider select can only be changed in a short window after reset. After that it stays fixed, so the time base cannot drift under running software. A read of the counter high byte buffers the low byte, so a high-then-low byte pair always describes a single instant.

Top module: `ptimer_capture`

## Requirements
- R1: After synchronous reset, the counter, the control register, the flag register and the interrupt output are all zero, and the divide ratio is 1.
- R2: Control bits [1:0] select the divide ratio: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The counter advances by exactly one every ratio-th cycle and never changes by any other amount.
- R3: A control write in any of the first 64 cycles after reset is released replaces all 8 bits. A later control write updates bits [7:2] and keeps bits [1:0].
- R4: The counter wraps from 0xFFFF to 0x0000. That wrap sets flag bit 7 (overflow).
- R5: A write to the flag register (address 9) clears each flag whose data bit is 1 and leaves flags under 0 bits unchanged. A hardware set in the same cycle wins over the clear. Only bits 7 and 2:0 exist; the other bits read 0.
- R6: A capture strobe with channel number k (1 to 3) stores the current count in capture register k and sets flag bit k-1. Channel number 0 has no effect.
- R7: Register addresses: counter high/low at 0/1, capture k high/low at 2k/2k+1, control at 8, flags at 9. High bytes are at the even address. Read data appears on the cycle after the read strobe and holds until the next read. Unmapped addresses read 0.
- R8: A read of the counter high byte buffers the counter low byte. The next low-byte read returns that buffered value. A low-byte read with no buffered value pending returns the live low byte.
- R9: The interrupt output is high exactly when flag bit 7 and control bit 7 are both set.
- R10: Writes to the counter and capture addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_strobe | input | 1 | One-cycle capture request |
| cap_sel | input | 2 | Capture channel number, 1 to 3; 0 ignored |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The properties assume that read and write strobes are never both high in one cycle. They also assume that a capture strobe lasts a single cycle, with a channel number that is stable while the strobe is high. The stimulus picks at most one register operation per cycle and drives every input at the falling edge. Capture strobes are drawn with their own probability, so captures collide freely with flag writes and counter reads. That collision case is exactly what the set-wins-over-clear rule governs.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  localparam int BYTE_W    = 8;
  localparam int OVF_BIT   = 7;
  localparam int IE_BIT    = 7;
  localparam int PS_W      = 2;
  localparam int DIV_W     = 4;

  // Last divider state before a tick for each select code.
  function automatic logic [DIV_W-1:0] ps_last(input logic [PS_W-1:0] s);
    unique case (s)
      2'd0:    return 4'd0;
      2'd1:    return 4'd3;
      2'd2:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler
  import ptimer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);

  logic [DIV_W-1:0] div_q;

  // Using >= lets a shrinking ratio settle without a full wrap.
  assign tick = (div_q >= ps_last(sel));

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ptimer_capture_bank.sv
module ptimer_capture_bank #(
  parameter int N_CAP = 3,
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        strobe,
  input  logic [SEL_W-1:0]            sel,
  input  logic [CNT_W-1:0]            cnt,
  output logic [N_CAP-1:0][CNT_W-1:0] cap_q,
  output logic [N_CAP-1:0]            hit
);

  for (genvar k = 0; k < N_CAP; k++) begin : g_chan
    assign hit[k] = strobe && (sel == SEL_W'(k + 1));

    always_ff @(posedge clk) begin
      if (rst)         cap_q[k] <= '0;
      else if (hit[k]) cap_q[k] <= cnt;
    end
  end

endmodule

// File: rtl/ptimer_lock.sv
module ptimer_lock #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  output logic unlocked
);

  localparam int AGE_W = $clog2(LOCK_CYCLES + 1);

  logic [AGE_W-1:0] age_q;

  assign unlocked = (age_q < AGE_W'(LOCK_CYCLES));

  always_ff @(posedge clk) begin
    if (rst)           age_q <= '0;
    else if (unlocked) age_q <= age_q + 1'b1;
  end

endmodule

// File: rtl/ptimer_capture.sv
module ptimer_capture
  import ptimer_pkg::*;
#(
  parameter int N_CAP       = 3,
  parameter int ADDR_W      = 4,
  parameter int LOCK_CYCLES = 64,
  parameter int SEL_W       = $clog2(N_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_strobe,
  input  logic [SEL_W-1:0]  cap_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ovf_irq
);

  localparam int CNT_W      = 16;
  localparam int CNT_HI     = 0;
  localparam int CNT_LO     = 1;
  localparam int CAP_BASE   = 2;
  localparam int CTRL_ADDR  = CAP_BASE + 2 * N_CAP;
  localparam int FLAGS_ADDR = CTRL_ADDR + 1;
  localparam logic [7:0] FLAG_MASK = 8'((1 << OVF_BIT) | ((1 << N_CAP) - 1));

  logic                        tick;
  logic                        wrap;
  logic                        unlocked;
  logic [CNT_W-1:0]            cnt_q;
  logic [N_CAP-1:0][CNT_W-1:0] cap_q;
  logic [N_CAP-1:0]            cap_hit;
  logic [7:0]                  ctrl_q;
  logic [7:0]                  flags_q;
  logic [7:0]                  rdata_q;
  logic [7:0]                  lo_buf_q;
  logic                        lo_buf_vld_q;
  logic [7:0]                  rd_val;
  logic [7:0]                  flag_set;
  logic [7:0]                  flag_clr;
  logic                        wr_ctrl;
  logic                        wr_flags;
  logic                        rd_hi;
  logic                        rd_lo;

  ptimer_prescaler u_presc (
    .clk  (clk),
    .rst  (rst),
    .sel  (ctrl_q[PS_W-1:0]),
    .tick (tick)
  );

  ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .cnt  (cnt_q),
    .wrap (wrap)
  );

  ptimer_capture_bank #(.N_CAP(N_CAP), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_caps (
    .clk    (clk),
    .rst    (rst),
    .strobe (cap_strobe),
    .sel    (cap_sel),
    .cnt    (cnt_q),
    .cap_q  (cap_q),
    .hit    (cap_hit)
  );

  ptimer_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .unlocked (unlocked)
  );

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_flags = reg_wr && (reg_addr == ADDR_W'(FLAGS_ADDR));
  assign rd_hi    = reg_rd && (reg_addr == ADDR_W'(CNT_HI));
  assign rd_lo    = reg_rd && (reg_addr == ADDR_W'(CNT_LO));

  always_comb begin
    flag_set = '0;
    flag_set[OVF_BIT] = wrap;
    flag_set[N_CAP-1:0] = cap_hit;
    flag_clr = wr_flags ? reg_wdata : 8'h00;
  end

  // Control: divider select frozen once the lock window has passed.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      if (unlocked) ctrl_q <= reg_wdata;
      else          ctrl_q <= {reg_wdata[7:PS_W], ctrl_q[PS_W-1:0]};
    end
  end

  // Flags: write-one-to-clear, hardware set has priority.
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= ((flags_q & ~flag_clr) | flag_set) & FLAG_MASK;
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == ADDR_W'(CNT_HI))          rd_val = cnt_q[15:8];
    else if (reg_addr == ADDR_W'(CNT_LO))     rd_val = lo_buf_vld_q ? lo_buf_q : cnt_q[7:0];
    else if (reg_addr == ADDR_W'(CTRL_ADDR))  rd_val = ctrl_q;
    else if (reg_addr == ADDR_W'(FLAGS_ADDR)) rd_val = flags_q;
    for (int k = 0; k < N_CAP; k++) begin
      if (reg_addr == ADDR_W'(CAP_BASE + 2 * k))     rd_val = cap_q[k][15:8];
      if (reg_addr == ADDR_W'(CAP_BASE + 2 * k + 1)) rd_val = cap_q[k][7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q      <= '0;
      lo_buf_q     <= '0;
      lo_buf_vld_q <= 1'b0;
    end else begin
      if (reg_rd) rdata_q <= rd_val;
      if (rd_hi) begin
        lo_buf_q     <= cnt_q[7:0];
        lo_buf_vld_q <= 1'b1;
      end else if (rd_lo) begin
        lo_buf_vld_q <= 1'b0;
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign ovf_irq   = flags_q[OVF_BIT] & ctrl_q[IE_BIT];

endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker #(
  parameter int N_CAP      = 3,
  parameter int CNT_W      = 16,
  parameter int SEL_W      = 2,
  parameter int ADDR_W     = 4,
  parameter int FLAGS_ADDR = 9
) (
  input logic                        clk,
  input logic                        rst,
  input logic [CNT_W-1:0]            cnt_q,
  input logic [N_CAP-1:0][CNT_W-1:0] cap_q,
  input logic [7:0]                  ctrl_q,
  input logic [7:0]                  flags_q,
  input logic                        unlocked,
  input logic                        cap_strobe,
  input logic [SEL_W-1:0]            cap_sel,
  input logic                        reg_wr,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [7:0]                  reg_wdata,
  input logic                        ovf_irq
);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_div1_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1:0] == 2'b00) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_ps_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(ctrl_q[1:0]));

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == {CNT_W{1'b1}}) || flags_q[7]);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(FLAGS_ADDR) && reg_wdata[0] &&
     !(cap_strobe && cap_sel == SEL_W'(1))) |=> !flags_q[0]);

  for (genvar k = 0; k < N_CAP; k++) begin : g_cap
    assert_cap_R6: assert property (@(posedge clk) disable iff (rst)
      (cap_strobe && cap_sel == SEL_W'(k + 1)) |=> (cap_q[k] == $past(cnt_q)));
  end

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[7] |-> !ovf_irq);

endmodule

bind ptimer_capture ptimer_checker #(
  .N_CAP(N_CAP), .CNT_W(CNT_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cnt_q(cnt_q), .cap_q(cap_q), .ctrl_q(ctrl_q),
  .flags_q(flags_q), .unlocked(unlocked), .cap_strobe(cap_strobe),
  .cap_sel(cap_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ovf_irq(ovf_irq)
);

// File: tb/test_ptimer_capture.sv
`timescale 1ns/1ps
module test_ptimer_capture;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cap_strobe = 1'b0;
  logic [1:0] cap_sel = '0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ovf_irq;

  always #2 clk = ~clk;

  ptimer_capture i_ptimer_capture (
    .clk(clk), .rst(rst), .cap_strobe(cap_strobe), .cap_sel(cap_sel),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_irq(ovf_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // Reference state built from the requirements.
  logic [15:0] m_cnt, m_cap [3];
  logic [7:0]  m_ctrl, m_flags, m_rdata, m_buf;
  logic        m_bvld;
  int          m_div, m_age;

  function automatic int ratio(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    if (a == 4'd0) return "R2";
    if (a == 4'd1) return "R8";
    if (a >= 4'd2 && a <= 4'd7) return "R6";
    if (a == 4'd8) return "R3";
    if (a == 4'd9) return "R5";
    return "R7";
  endfunction

  always @(posedge clk) begin : ref_model
    logic tk;
    logic [7:0] setv, clrv;
    if (rst) begin
      m_cnt = '0; m_ctrl = '0; m_flags = '0; m_rdata = '0; m_buf = '0;
      m_bvld = 1'b0; m_div = 0; m_age = 0;
      for (int k = 0; k < 3; k++) m_cap[k] = '0;
    end else begin
      if (reg_rd) begin
        case (reg_addr)
          4'd0: begin m_rdata = m_cnt[15:8]; m_buf = m_cnt[7:0]; m_bvld = 1'b1; end
          4'd1: begin m_rdata = m_bvld ? m_buf : m_cnt[7:0]; m_bvld = 1'b0; end
          4'd2: m_rdata = m_cap[0][15:8];
          4'd3: m_rdata = m_cap[0][7:0];
          4'd4: m_rdata = m_cap[1][15:8];
          4'd5: m_rdata = m_cap[1][7:0];
          4'd6: m_rdata = m_cap[2][15:8];
          4'd7: m_rdata = m_cap[2][7:0];
          4'd8: m_rdata = m_ctrl;
          4'd9: m_rdata = m_flags;
          default: m_rdata = 8'h00;
        endcase
      end
      tk = (m_div >= ratio(m_ctrl[1:0]) - 1);
      setv = 8'h00;
      if (tk && m_cnt == 16'hFFFF) setv[7] = 1'b1;
      if (cap_strobe && cap_sel != 2'd0) begin
        setv[cap_sel - 1] = 1'b1;
        m_cap[cap_sel - 1] = m_cnt;
      end
      clrv = (reg_wr && reg_addr == 4'd9) ? reg_wdata : 8'h00;
      m_flags = ((m_flags & ~clrv) | setv) & 8'h87;
      if (reg_wr && reg_addr == 4'd8)
        m_ctrl = (m_age < 64) ? reg_wdata : {reg_wdata[7:2], m_ctrl[1:0]};
      if (m_age < 64) m_age++;
      if (tk) begin m_div = 0; m_cnt = m_cnt + 16'd1; end
      else m_div++;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected<200000", cyc);
      finish_run();
    end
  end

  logic       rd_pend = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] last_rd;

  task automatic step(input bit rd, input bit wr, input logic [3:0] a,
                      input logic [7:0] d, input bit cs, input logic [1:0] sel);
    @(negedge clk);
    last_rd = reg_rdata;
    if (rd_pend) chk(req_of(rd_addr), reg_rdata, m_rdata);
    chk("R9", {7'd0, ovf_irq}, {7'd0, m_ctrl[7] & m_flags[7]});
    rd_pend = rd; rd_addr = a;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    cap_strobe = cs; cap_sel = sel;
  endtask

  task automatic idle(); step(0, 0, 4'd0, 8'h00, 0, 2'd0); endtask

  task automatic rd_byte(input logic [3:0] a, output logic [7:0] v);
    step(1, 0, a, 8'h00, 0, 2'd0);
    idle();
    v = last_rd;
  endtask

  task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
    step(0, 1, a, d, 0, 2'd0);
  endtask

  task automatic do_reset();
    idle();
    rst = 1'b1;
    repeat (3) idle();
    rst = 1'b0;
  endtask

  task automatic rnd_step(input logic [7:0] ctrl_mask, input logic [7:0] flag_mask);
    int r;
    logic [3:0] a;
    logic [7:0] d;
    r = $urandom_range(0, 99);
    a = 4'($urandom_range(0, 15));
    d = 8'($urandom);
    if (a == 4'd8) d = d & ctrl_mask;
    if (a == 4'd9) d = d & flag_mask;
    step(r < 40, r >= 40 && r < 55, a, d, $urandom_range(0, 19) == 0,
         2'($urandom_range(0, 3)));
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R1: reset state
    rd_byte(4'd8, v); chk("R1", v, 8'h00);
    rd_byte(4'd9, v); chk("R1", v, 8'h00);
    rd_byte(4'd0, v); chk("R1", v, 8'h00);
    chk("R1", {7'd0, ovf_irq}, 8'h00);

    // R3: early write takes all bits (divider stays 1)
    wr_byte(4'd8, 8'h7C);
    rd_byte(4'd8, v); chk("R3", v, 8'h7C);

    // R6: channel 0 ignored, channel 2 captures
    step(0, 0, 4'd0, 8'h00, 1, 2'd0);
    rd_byte(4'd9, v); chk("R6", v, 8'h00);
    step(0, 0, 4'd0, 8'h00, 1, 2'd2);
    rd_byte(4'd9, v); chk("R6", v, 8'h02);
    rd_byte(4'd4, v); chk("R6", v, m_cap[1][15:8]);

    // R10: writes to counter and capture addresses ignored
    wr_byte(4'd5, 8'hA5);
    wr_byte(4'd0, 8'hFF);
    rd_byte(4'd5, v); chk("R10", v, m_cap[1][7:0]);
    rd_byte(4'd0, v); chk("R10", v, m_cnt[15:8]);

    // R7: unmapped address reads zero
    rd_byte(4'd13, v); chk("R7", v, 8'h00);

    // Long run at divide-by-1 through one wrap; overflow flag kept
    repeat (66000) rnd_step(8'hFC, 8'h07);
    rd_byte(4'd9, v); chk("R4", v & 8'h80, 8'h80);
    wr_byte(4'd8, 8'h80);
    idle();
    chk("R9", {7'd0, ovf_irq}, 8'h01);
    wr_byte(4'd9, 8'h00);
    rd_byte(4'd9, v); chk("R5", v & 8'h80, 8'h80);
    wr_byte(4'd9, 8'h80);
    rd_byte(4'd9, v); chk("R5", v & 8'h80, 8'h00);

    // Divide by 4, random traffic
    do_reset();
    wr_byte(4'd8, 8'h01);
    repeat (3000) rnd_step(8'hFF, 8'hFF);

    // R3: late write keeps divider select
    do_reset();
    repeat (70) idle();
    wr_byte(4'd8, 8'h43);
    rd_byte(4'd8, v); chk("R3", v, 8'h40);

    // Divide by 16, read-heavy random traffic, coherent pairs
    do_reset();
    wr_byte(4'd8, 8'h03);
    repeat (4) begin
      rd_byte(4'd0, v);
      repeat (20) idle();
      rd_byte(4'd1, v); chk("R8", v, m_rdata);
    end
    repeat (3000) rnd_step(8'hFF, 8'hFF);

    idle(); idle();
    finish_run();
  end

endmodule